// File: doc/BRIEF.md
# Trigger Hold and Start Timer

This block sequences an analogue front end around an external trigger. An asynchronous trigger line is brought into the clock domain through a synchroniser, and only its low-to-high transitions count. On such a transition, and only when the converter is idle and the data-ready indication is low, the block waits a short programmed delay and then switches the sample-and-hold control to hold. After a further settling interval it issues a single-cycle conversion start. When the converter reports completion, the control returns to sample.

Separately, each time the data-ready indication goes high, the block drives an active-low trigger-out line for a fixed number of clock cycles. All intervals are clock-cycle counts set by parameters. With a 50 MHz clock the defaults give roughly 60 ns, 200 ns and 1 µs. The block carries no data stream: every pin is a plain control or status level or pulse. `data_ready` and `conv_done` are taken as synchronous to `clk`. Only `trig_in` is treated as asynchronous.

Top module: `trig_hold_timer`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, `sh_hold` is 0 (sample), `conv_start` is 0 and `trig_out_n` is 1.
- R2: A low-to-high change on `trig_in`, seen while idle with `data_ready` low, sets `sh_hold` to 1 exactly SYNC_STAGES+1+HOLD_CYC clock edges after the first edge that samples the new level.
- R3: `conv_start` is high for exactly one cycle, SETTLE_CYC edges after `sh_hold` rises, and `sh_hold` is 1 in that cycle.
- R4: After `conv_start`, `sh_hold` stays 1 until a cycle with `conv_done` high, and is 0 on the following cycle.
- R5: A trigger rising edge that arrives while `data_ready` is 1 and the block is idle is ignored: `sh_hold` and `conv_start` stay 0.
- R6: A trigger rising edge that arrives during an active delay, settle or conversion is dropped, not queued: no second cycle follows the first.
- R7: Only low-to-high transitions start a cycle; a trigger held high or falling has no effect.
- R8: A rising edge of `data_ready` drives `trig_out_n` to 0 from the next cycle for exactly PULSE_CYC cycles.
- R9: A further rising edge of `data_ready` while `trig_out_n` is low restarts the width, so the line stays low for PULSE_CYC cycles after that new edge.
- R10: `conv_done` outside the conversion phase (idle or settling) has no effect on `sh_hold` or on the timing of `conv_start`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| trig_in | input | 1 | External trigger, asynchronous, rising edge active |
| data_ready | input | 1 | Data-ready indication, synchronous, 1 = data pending |
| conv_done | input | 1 | Converter completion pulse, synchronous |
| sh_hold | output | 1 | Sample-and-hold control, 1 = hold, 0 = sample |
| conv_start | output | 1 | One-cycle conversion start pulse |
| trig_out_n | output | 1 | Active-low trigger-out pulse |

## Verification
The assertions assume that `data_ready` and `conv_done` change only in step with `clk`. They also assume that `conv_done` is a completion report from the converter, so any pulse outside the conversion phase is ignored rather than checked for a response. The bench drives every input on the falling clock edge and samples outputs there, so the synchronous inputs never change near an active edge. Trigger changes are spaced several cycles apart, so each transition passes the synchroniser cleanly. Stray `conv_done` pulses are issued only in the idle and settle phases, where the requirement says they do nothing.

// File: rtl/tht_pkg.sv
`timescale 1ns/1ps
package tht_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE    = 2'd0,
    SEQ_DELAY   = 2'd1,
    SEQ_SETTLE  = 2'd2,
    SEQ_CONVERT = 2'd3
  } seq_state_e;

  function automatic int unsigned cnt_bits(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/trig_edge_sync.sv
`timescale 1ns/1ps
module trig_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise
);
  localparam int unsigned W = STAGES + 1;

  logic [W-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[W-2:0], async_in};
  end

  // chain[STAGES-1] is the settled level, chain[STAGES] its previous value
  assign rise = chain[STAGES-1] & ~chain[STAGES];
endmodule

// File: rtl/hold_sequencer.sv
`timescale 1ns/1ps
module hold_sequencer
  import tht_pkg::*;
#(
  parameter int unsigned HOLD_CYC   = 3,
  parameter int unsigned SETTLE_CYC = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig_rise,
  input  logic flag,
  input  logic conv_done,
  output logic sh_hold,
  output logic conv_start
);
  localparam int unsigned MAXC = (HOLD_CYC > SETTLE_CYC) ? HOLD_CYC : SETTLE_CYC;
  localparam int unsigned CW   = cnt_bits(MAXC);
  localparam logic [CW-1:0] HOLD_LAST   = CW'(HOLD_CYC - 1);
  localparam logic [CW-1:0] SETTLE_LAST = CW'(SETTLE_CYC - 1);

  seq_state_e     state;
  logic [CW-1:0]  cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= SEQ_IDLE;
      cnt        <= '0;
      sh_hold    <= 1'b0;
      conv_start <= 1'b0;
    end else begin
      conv_start <= 1'b0;
      unique case (state)
        SEQ_IDLE: begin
          cnt <= '0;
          if (trig_rise && !flag) state <= SEQ_DELAY;
        end
        SEQ_DELAY: begin
          if (cnt == HOLD_LAST) begin
            cnt     <= '0;
            sh_hold <= 1'b1;
            state   <= SEQ_SETTLE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        SEQ_SETTLE: begin
          if (cnt == SETTLE_LAST) begin
            cnt        <= '0;
            conv_start <= 1'b1;
            state      <= SEQ_CONVERT;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        SEQ_CONVERT: begin
          if (conv_done) begin
            sh_hold <= 1'b0;
            state   <= SEQ_IDLE;
          end
        end
        default: state <= SEQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/flag_pulse_gen.sv
`timescale 1ns/1ps
module flag_pulse_gen
  import tht_pkg::*;
#(
  parameter int unsigned PULSE_CYC = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic flag,
  output logic pulse_n
);
  localparam int unsigned CW = cnt_bits(PULSE_CYC);
  localparam logic [CW-1:0] LAST = CW'(PULSE_CYC - 1);

  logic          flag_q;
  logic [CW-1:0] cnt;
  logic          flag_rise;

  assign flag_rise = flag & ~flag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q  <= 1'b0;
      cnt     <= '0;
      pulse_n <= 1'b1;
    end else begin
      flag_q <= flag;
      if (flag_rise) begin
        cnt     <= '0;
        pulse_n <= 1'b0;
      end else if (!pulse_n) begin
        if (cnt == LAST) pulse_n <= 1'b1;
        else             cnt     <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/trig_hold_timer.sv
`timescale 1ns/1ps
module trig_hold_timer #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned HOLD_CYC    = 3,
  parameter int unsigned SETTLE_CYC  = 10,
  parameter int unsigned PULSE_CYC   = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig_in,
  input  logic data_ready,
  input  logic conv_done,
  output logic sh_hold,
  output logic conv_start,
  output logic trig_out_n
);
  logic trig_rise;

  trig_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (trig_in),
    .rise     (trig_rise)
  );

  hold_sequencer #(.HOLD_CYC(HOLD_CYC), .SETTLE_CYC(SETTLE_CYC)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .trig_rise  (trig_rise),
    .flag       (data_ready),
    .conv_done  (conv_done),
    .sh_hold    (sh_hold),
    .conv_start (conv_start)
  );

  flag_pulse_gen #(.PULSE_CYC(PULSE_CYC)) u_pulse (
    .clk     (clk),
    .rst_n   (rst_n),
    .flag    (data_ready),
    .pulse_n (trig_out_n)
  );
endmodule

// File: rtl/trig_hold_timer_chk.sv
`timescale 1ns/1ps
module trig_hold_timer_chk #(
  parameter int unsigned PULSE_CYC = 50
) (
  input logic clk,
  input logic rst_n,
  input logic data_ready,
  input logic conv_done,
  input logic sh_hold,
  input logic conv_start,
  input logic trig_out_n
);
  localparam int unsigned SW = $clog2(PULSE_CYC + 2);
  localparam logic [SW-1:0] SAT = SW'(PULSE_CYC);

  logic          converting;
  logic          flag_q;
  logic [SW-1:0] since_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      converting <= 1'b0;
      flag_q     <= 1'b0;
      since_rise <= SAT;
    end else begin
      flag_q <= data_ready;
      if (conv_start)     converting <= 1'b1;
      else if (conv_done) converting <= 1'b0;
      if (data_ready && !flag_q)  since_rise <= '0;
      else if (since_rise != SAT) since_rise <= since_rise + 1'b1;
    end
  end

  a_r3_start_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start);

  a_r3_start_in_hold: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> sh_hold);

  a_r2_hold_before_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sh_hold) |-> !conv_start);

  a_r4_hold_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (sh_hold && !conv_done) |=> sh_hold);

  a_r4_release: assert property (@(posedge clk) disable iff (!rst_n)
    (converting && conv_done) |=> !sh_hold);

  a_r8_pulse_begin: assert property (@(posedge clk) disable iff (!rst_n)
    (data_ready && !flag_q) |=> !trig_out_n);

  a_r9_pulse_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    !trig_out_n |-> (since_rise < SAT));
endmodule

bind trig_hold_timer trig_hold_timer_chk #(.PULSE_CYC(PULSE_CYC)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .data_ready (data_ready),
  .conv_done  (conv_done),
  .sh_hold    (sh_hold),
  .conv_start (conv_start),
  .trig_out_n (trig_out_n)
);

// File: tb/trig_hold_timer_bench.sv
`timescale 1ns/1ps
module trig_hold_timer_bench;
  localparam int unsigned SS = 2;
  localparam int unsigned HC = 3;
  localparam int unsigned SC = 10;
  localparam int unsigned PC = 50;
  localparam int unsigned LAT = SS + 1 + HC;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic trig_in = 1'b0;
  logic data_ready = 1'b0;
  logic conv_done = 1'b0;
  logic sh_hold, conv_start, trig_out_n;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  trig_hold_timer #(.SYNC_STAGES(SS), .HOLD_CYC(HC), .SETTLE_CYC(SC), .PULSE_CYC(PC))
  u_trig_hold_timer (
    .clk(clk), .rst_n(rst_n), .trig_in(trig_in), .data_ready(data_ready),
    .conv_done(conv_done), .sh_hold(sh_hold), .conv_start(conv_start),
    .trig_out_n(trig_out_n)
  );

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic actual, input logic expected);
    checks++;
    if (actual !== expected) begin
      fails++;
      $display("FAIL %s actual=%0b expected=%0b", tag, actual, expected);
    end
  endtask

  task automatic t_reset();
    chk("R1 hold in reset", sh_hold, 1'b0);
    chk("R1 start in reset", conv_start, 1'b0);
    chk("R1 trig_out_n in reset", trig_out_n, 1'b1);
    rst_n = 1'b1;
    step();
    chk("R1 hold after reset", sh_hold, 1'b0);
    chk("R1 trig_out_n after reset", trig_out_n, 1'b1);
  endtask

  task automatic t_basic();
    trig_in = 1'b1;
    repeat (LAT - 1) step();
    chk("R2 hold not yet", sh_hold, 1'b0);
    step();
    chk("R2 hold asserted", sh_hold, 1'b1);
    repeat (SC - 1) step();
    chk("R3 start not yet", conv_start, 1'b0);
    step();
    chk("R3 start pulse", conv_start, 1'b1);
    chk("R3 hold during start", sh_hold, 1'b1);
    step();
    chk("R3 start one cycle", conv_start, 1'b0);
    repeat (3) step();
    chk("R4 hold kept while converting", sh_hold, 1'b1);
    conv_done = 1'b1;
    step();
    conv_done = 1'b0;
    chk("R4 sample after done", sh_hold, 1'b0);
    trig_in = 1'b0;
    repeat (4) step();
  endtask

  task automatic t_flag_block();
    logic seen = 1'b0;
    data_ready = 1'b1;
    repeat (2) step();
    trig_in = 1'b1;
    for (int i = 0; i < int'(LAT + SC + 3); i++) begin
      step();
      if (sh_hold || conv_start) seen = 1'b1;
    end
    chk("R5 trigger ignored while data ready", seen, 1'b0);
    trig_in = 1'b0;
    data_ready = 1'b0;
    repeat (PC + 5) step();
  endtask

  task automatic t_no_queue();
    logic seen = 1'b0;
    trig_in = 1'b1;
    repeat (4) step();
    trig_in = 1'b0;
    repeat (3) step();
    trig_in = 1'b1;
    repeat (LAT + SC - 7) step();
    chk("R6 first cycle undisturbed", conv_start, 1'b1);
    step();
    conv_done = 1'b1;
    step();
    conv_done = 1'b0;
    chk("R6 back to sample", sh_hold, 1'b0);
    for (int i = 0; i < int'(LAT + SC + 4); i++) begin
      step();
      if (sh_hold || conv_start) seen = 1'b1;
    end
    chk("R6 no queued cycle, R7 level high ignored", seen, 1'b0);
    trig_in = 1'b0;
    seen = 1'b0;
    for (int i = 0; i < 20; i++) begin
      step();
      if (sh_hold || conv_start) seen = 1'b1;
    end
    chk("R7 falling edge ignored", seen, 1'b0);
  endtask

  task automatic t_done_ignored();
    conv_done = 1'b1;
    step();
    conv_done = 1'b0;
    step();
    chk("R10 idle done no hold", sh_hold, 1'b0);
    trig_in = 1'b1;
    repeat (LAT + 2) step();
    conv_done = 1'b1;
    step();
    conv_done = 1'b0;
    chk("R10 hold kept on settle done", sh_hold, 1'b1);
    repeat (SC - 4) step();
    chk("R10 start not early", conv_start, 1'b0);
    step();
    chk("R10 start on time", conv_start, 1'b1);
    step();
    conv_done = 1'b1;
    step();
    conv_done = 1'b0;
    chk("R4 release after real done", sh_hold, 1'b0);
    trig_in = 1'b0;
    repeat (4) step();
  endtask

  task automatic t_pulse();
    data_ready = 1'b1;
    step();
    chk("R8 pulse starts", trig_out_n, 1'b0);
    repeat (PC - 1) step();
    chk("R8 pulse last low cycle", trig_out_n, 1'b0);
    step();
    chk("R8 pulse ends", trig_out_n, 1'b1);
    data_ready = 1'b0;
    repeat (3) step();
    chk("R8 no pulse on fall", trig_out_n, 1'b1);
  endtask

  task automatic t_restart();
    data_ready = 1'b1;
    repeat (10) step();
    data_ready = 1'b0;
    step();
    data_ready = 1'b1;
    repeat (PC - 10) step();
    chk("R9 still low past first width", trig_out_n, 1'b0);
    repeat (10) step();
    chk("R9 low until restarted width", trig_out_n, 1'b0);
    step();
    chk("R9 ends after restarted width", trig_out_n, 1'b1);
    data_ready = 1'b0;
    repeat (3) step();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    t_reset();
    t_basic();
    t_flag_block();
    t_no_queue();
    t_done_ignored();
    t_pulse();
    t_restart();
    if (!finished) begin
      finished = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule